// File: doc/BRIEF.md
# Three-wire secure key slave

This block is the slave side of a small serial security key. It sits on a three-wire bus: a bus clock, an enable line that opens and closes each transaction, and one data line. The data line is modelled as a separate input, output and output-enable. The block runs on a fast system clock. It passes the three bus inputs through a synchronizer and acts on the detected bus-clock edges.

Every transaction opens with a 24-bit command. A normal-mode command makes the key shift out its 64-bit identifier. The key then takes in a 64-bit candidate code. If that code equals the stored match code, the next 128 cycles read or write the 128-bit secure memory, as the command selects. If the code differs, reads return pseudo-random bits, writes are dropped, and nothing marks the failure. A program-mode command loads a new identifier and a new match code. An invalid command leaves the key silent until the enable line drops.

Top module: `seckey_slave`

## Requirements
- R1: While `bus_en_i` is low the key never drives `dq_oe`. Dropping `bus_en_i` releases `dq_oe` at once, aborts the transaction, and the next transaction starts again from the command.
- R2: Command bits are received least significant first as c[0]..c[23]. The 8-bit value c[7:0] is 0x62 for read and 0x9D for write. {c[9],c[8]} is 2'b01 for normal mode and 2'b10 for program mode. c[22:10] must equal the `DEV_CODE` parameter, and c[23] must be 1. Program mode is accepted only with the write value.
- R3: In normal mode the 64 cycles after the command shift out the identifier, least significant bit first. Each bit is driven after a bus-clock falling edge, and `dq_oe` is released after the next rising edge.
- R4: The following 64 cycles sample a candidate code on rising edges, least significant bit first. Access is granted only when all 64 bits equal the stored match code.
- R5: After a granted match with the read command, the next 128 cycles drive the secure memory, least significant bit first.
- R6: After a granted match with the write command, the next 128 sampled bits replace the secure memory, least significant bit first.
- R7: After a failed match with the read command, all 128 cycles are still driven, but with pseudo-random bits from a free-running, non-zero 32-bit LFSR instead of the memory.
- R8: After a failed match with the write command, the secure memory is unchanged.
- R9: In program mode the 128 bits after the command load the identifier (first 64) and then the match code (last 64). In normal mode neither of them changes.
- R10: After an invalid command the key never drives the data line and changes no storage for the rest of the transaction.
- R11: Bus cycles beyond the last defined bit of a transaction are neither driven nor written.
- R12: After system reset the identifier, the match code and the secure memory all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_clk_i | input | 1 | Bus clock, asynchronous to `clk` |
| bus_en_i | input | 1 | Transaction enable; high opens a transaction, low ends it |
| dq_i | input | 1 | Data line as seen by the key |
| dq_o | output | 1 | Data bit the key drives |
| dq_oe | output | 1 | Output enable for the data line; low means high impedance |

## Verification
The assertions rely on each bus-clock level lasting at least four system clocks. They also rely on `dq_i` being steady from the falling edge through the following rising edge, so that the synchronized data and clock arrive together and each rising edge is seen exactly once. The bench holds every bus-clock half-period for five system clocks. It changes `dq_i` only together with a falling bus-clock edge, and it raises or lowers `bus_en_i` only while the bus clock is high, except in the one deliberate abort, which drops the enable with the clock low. The command sweeps flip every single bit of a valid normal-read command and of a valid program command, and each flip must yield an invalid command.

// File: rtl/seckey_pkg.sv
package seckey_pkg;

  localparam int CMD_BITS = 24;
  localparam int DEV_BITS = 13;
  localparam int LFSR_W   = 32;

  localparam logic [7:0] OP_READ  = 8'h62;
  localparam logic [7:0] OP_WRITE = 8'h9D;

  localparam logic [1:0] MODE_NORMAL  = 2'b01;
  localparam logic [1:0] MODE_PROGRAM = 2'b10;

  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ID,
    PH_CMP,
    PH_SEC,
    PH_PROG,
    PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    CMD_BAD,
    CMD_NORM_RD,
    CMD_NORM_WR,
    CMD_PROG
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [CMD_BITS-1:0] c,
                                           input logic [DEV_BITS-1:0] dev);
    cmd_kind_e res;
    logic is_rd;
    logic is_wr;
    logic frame_ok;
    is_rd    = (c[7:0] == OP_READ);
    is_wr    = (c[7:0] == OP_WRITE);
    frame_ok = c[CMD_BITS-1] && (c[CMD_BITS-2:10] == dev) && (is_rd || is_wr);
    res      = CMD_BAD;
    if (frame_ok) begin
      if (c[9:8] == MODE_NORMAL) begin
        res = is_rd ? CMD_NORM_RD : CMD_NORM_WR;
      end else if (c[9:8] == MODE_PROGRAM && is_wr) begin
        res = CMD_PROG;
      end
    end
    return res;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/seckey_sync.sv
module seckey_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= '0;
          else        pipe_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '0;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/seckey_lfsr.sv
module seckey_lfsr
  import seckey_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'h1D0F_5EED
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= (SEED == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : SEED;
    else        state <= lfsr_step(state);
  end
endmodule

// File: rtl/seckey_store.sv
module seckey_store #(
  parameter int ID_W   = 64,
  parameter int CODE_W = 64,
  parameter int MEM_W  = 128,
  localparam int ID_AW   = $clog2(ID_W),
  localparam int CODE_AW = $clog2(CODE_W),
  localparam int MEM_AW  = $clog2(MEM_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wbit,
  input  logic               id_we,
  input  logic [ID_AW-1:0]   id_idx,
  input  logic               code_we,
  input  logic [CODE_AW-1:0] code_idx,
  input  logic               mem_we,
  input  logic [MEM_AW-1:0]  mem_idx,
  output logic [ID_W-1:0]    id_q,
  output logic [CODE_W-1:0]  code_q,
  output logic [MEM_W-1:0]   mem_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else if (id_we) id_q[id_idx] <= wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else if (code_we) code_q[code_idx] <= wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (mem_we) mem_q[mem_idx] <= wbit;
  end
endmodule

// File: rtl/seckey_slave.sv
module seckey_slave
  import seckey_pkg::*;
#(
  parameter int                  ID_W        = 64,
  parameter int                  CODE_W      = 64,
  parameter int                  MEM_W       = 128,
  parameter logic [DEV_BITS-1:0] DEV_CODE    = 13'h0155,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [LFSR_W-1:0]   LFSR_SEED   = 32'h1D0F_5EED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_en_i,
  input  logic dq_i,
  output logic dq_o,
  output logic dq_oe
);
  localparam int PROG_LEN = ID_W + CODE_W;
  localparam int LONGEST  = (PROG_LEN > MEM_W) ? PROG_LEN : MEM_W;
  localparam int CNT_W    = $clog2(LONGEST) + 1;
  localparam int ID_AW    = $clog2(ID_W);
  localparam int CODE_AW  = $clog2(CODE_W);
  localparam int MEM_AW   = $clog2(MEM_W);

  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_ID   = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] LAST_MEM  = CNT_W'(MEM_W - 1);
  localparam logic [CNT_W-1:0] LAST_PROG = CNT_W'(PROG_LEN - 1);

  // synchronized bus inputs and bus-clock edges
  logic [2:0] sync_q;
  logic       clk_s;
  logic       en_s;
  logic       dq_s;
  logic       clk_prev_q;
  logic       rise_ev;
  logic       fall_ev;

  seckey_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({dq_i, bus_en_i, bus_clk_i}),
    .q     (sync_q)
  );

  assign clk_s = sync_q[0];
  assign en_s  = sync_q[1];
  assign dq_s  = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= clk_s;
  end

  assign rise_ev = en_s &  clk_s & ~clk_prev_q;
  assign fall_ev = en_s & ~clk_s &  clk_prev_q;

  // transaction state
  phase_e              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [CODE_W-1:0]   cmp_q;
  logic                rd_mode_q;
  logic                matched_q;
  logic                drive_q;
  logic                dout_q;

  logic [CMD_BITS-1:0] cmd_next;
  logic [CODE_W-1:0]   cmp_next;
  cmd_kind_e           cmd_kind;

  assign cmd_next = {dq_s, cmd_q[CMD_BITS-1:1]};
  assign cmp_next = {dq_s, cmp_q[CODE_W-1:1]};
  assign cmd_kind = decode_cmd(cmd_next, DEV_CODE);

  // storage and random source
  logic [ID_W-1:0]   id_q;
  logic [CODE_W-1:0] code_q;
  logic [MEM_W-1:0]  mem_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              id_we;
  logic              code_we;
  logic              mem_we;
  logic [CNT_W-1:0]  code_off;
  logic              id_bit;
  logic              mem_bit;
  logic              rnd_bit;

  assign id_we    = rise_ev && (phase_q == PH_PROG) && (cnt_q <  CNT_W'(ID_W));
  assign code_we  = rise_ev && (phase_q == PH_PROG) && (cnt_q >= CNT_W'(ID_W));
  assign mem_we   = rise_ev && (phase_q == PH_SEC) && !rd_mode_q && matched_q;
  assign code_off = cnt_q - CNT_W'(ID_W);
  assign id_bit   = id_q[cnt_q[ID_AW-1:0]];
  assign mem_bit  = mem_q[cnt_q[MEM_AW-1:0]];
  assign rnd_bit  = lfsr_q[0];

  seckey_store #(.ID_W(ID_W), .CODE_W(CODE_W), .MEM_W(MEM_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wbit     (dq_s),
    .id_we    (id_we),
    .id_idx   (cnt_q[ID_AW-1:0]),
    .code_we  (code_we),
    .code_idx (code_off[CODE_AW-1:0]),
    .mem_we   (mem_we),
    .mem_idx  (cnt_q[MEM_AW-1:0]),
    .id_q     (id_q),
    .code_q   (code_q),
    .mem_q    (mem_q)
  );

  seckey_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  // phase sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      cnt_q     <= '0;
      cmd_q     <= '0;
      cmp_q     <= '0;
      rd_mode_q <= 1'b0;
      matched_q <= 1'b0;
      drive_q   <= 1'b0;
      dout_q    <= 1'b0;
    end else if (!en_s) begin
      phase_q   <= PH_CMD;
      cnt_q     <= '0;
      rd_mode_q <= 1'b0;
      matched_q <= 1'b0;
      drive_q   <= 1'b0;
    end else if (rise_ev) begin
      drive_q <= 1'b0;
      unique case (phase_q)
        PH_CMD: begin
          cmd_q <= cmd_next;
          if (cnt_q == LAST_CMD) begin
            cnt_q     <= '0;
            rd_mode_q <= (cmd_kind == CMD_NORM_RD);
            unique case (cmd_kind)
              CMD_NORM_RD, CMD_NORM_WR: phase_q <= PH_ID;
              CMD_PROG:                 phase_q <= PH_PROG;
              default:                  phase_q <= PH_DONE;
            endcase
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_ID: begin
          if (cnt_q == LAST_ID) begin
            cnt_q   <= '0;
            phase_q <= PH_CMP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_CMP: begin
          cmp_q <= cmp_next;
          if (cnt_q == LAST_CODE) begin
            cnt_q     <= '0;
            matched_q <= (cmp_next == code_q);
            phase_q   <= PH_SEC;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_SEC: begin
          if (cnt_q == LAST_MEM) phase_q <= PH_DONE;
          else                   cnt_q   <= cnt_q + CNT_W'(1);
        end
        PH_PROG: begin
          if (cnt_q == LAST_PROG) phase_q <= PH_DONE;
          else                    cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end else if (fall_ev) begin
      if (phase_q == PH_ID) begin
        drive_q <= 1'b1;
        dout_q  <= id_bit;
      end else if (phase_q == PH_SEC && rd_mode_q) begin
        drive_q <= 1'b1;
        dout_q  <= matched_q ? mem_bit : rnd_bit;
      end
    end
  end

  assign dq_o  = dout_q;
  assign dq_oe = drive_q & bus_en_i;
endmodule

// File: rtl/seckey_checker.sv
module seckey_checker
  import seckey_pkg::*;
#(
  parameter int ID_W   = 64,
  parameter int CODE_W = 64,
  parameter int MEM_W  = 128,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic              rise_ev,
  input logic              drive_q,
  input phase_e            phase,
  input logic              rd_mode,
  input logic              matched,
  input logic [CNT_W-1:0]  cnt,
  input logic [LFSR_W-1:0] lfsr,
  input logic [ID_W-1:0]   id_v,
  input logic [CODE_W-1:0] code_v,
  input logic [MEM_W-1:0]  mem_v
);
  localparam int PROG_LEN = ID_W + CODE_W;
  localparam int LONGEST  = (PROG_LEN > MEM_W) ? PROG_LEN : MEM_W;

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !drive_q); // R1

  AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !drive_q); // R3

  AST_GRANT_AFTER_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched) |-> (phase == PH_SEC)); // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LONGEST)); // R5

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R7

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_SEC || !matched || rd_mode) |=> $stable(mem_v)); // R8

  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_PROG) |=> $stable(id_v)); // R9

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_PROG) |=> $stable(code_v)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> !drive_q); // R10

  AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (phase == PH_ID || (phase == PH_SEC && rd_mode))); // R11
endmodule

bind seckey_slave seckey_checker #(
  .ID_W(ID_W), .CODE_W(CODE_W), .MEM_W(MEM_W), .CNT_W(CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_s    (en_s),
  .rise_ev (rise_ev),
  .drive_q (drive_q),
  .phase   (phase_q),
  .rd_mode (rd_mode_q),
  .matched (matched_q),
  .cnt     (cnt_q),
  .lfsr    (lfsr_q),
  .id_v    (id_q),
  .code_v  (code_q),
  .mem_v   (mem_q)
);

// File: tb/seckey_slave_tb_top.sv
module seckey_slave_tb_top;
  localparam logic [7:0]  RD_OP = 8'h62;
  localparam logic [7:0]  WR_OP = 8'h9D;
  localparam logic [12:0] DEV   = 13'h0155;
  localparam int          HALF  = 5;

  localparam logic [63:0]  ID_A   = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0]  CODE_A = 64'hA5C3_1E7F_0D92_B846;
  localparam logic [63:0]  ID_B   = 64'hFFEE_DDCC_BBAA_9988;
  localparam logic [63:0]  CODE_B = 64'h1357_9BDF_2468_ACE0;
  localparam logic [127:0] WD_A   = 128'hDEAD_BEEF_0F1E_2D3C_4B5A_6978_8796_A5B4;
  localparam logic [127:0] WD_B   = 128'h0000_FFFF_1234_5678_9ABC_DEF0_5555_AAAA;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic bclk  = 1'b1;
  logic ben   = 1'b0;
  logic dqi   = 1'b0;
  logic dqo;
  logic dqoe;

  int checks  = 0;
  int errors  = 0;
  int rel_err = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  seckey_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_clk_i (bclk),
    .bus_en_i  (ben),
    .dq_i      (dqi),
    .dq_o      (dqo),
    .dq_oe     (dqoe)
  );

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit order per R2: c[7:0] opcode, c[8], c[9] mode, c[22:10] device, c[23] = 1
  function automatic logic [23:0] mk_cmd(input logic [7:0] op, input logic b8,
                                         input logic b9, input logic [12:0] dev);
    logic [23:0] c;
    c[7:0]   = op;
    c[8]     = b8;
    c[9]     = b9;
    c[22:10] = dev;
    c[23]    = 1'b1;
    return c;
  endfunction

  task automatic open_xfer();
    bclk = 1'b1;
    ben  = 1'b1;
    waitn(HALF);
  endtask

  task automatic close_xfer();
    bclk = 1'b1;
    ben  = 1'b0;
    waitn(HALF);
  endtask

  task automatic wr_bit(input logic b);
    bclk = 1'b0;
    dqi  = b;
    waitn(HALF);
    bclk = 1'b1;
    waitn(HALF);
  endtask

  task automatic wr_field(input logic [127:0] v, input int n);
    for (int i = 0; i < n; i++) wr_bit(v[i]);
  endtask

  task automatic rd_field(input int n, output logic [127:0] v, output int drv);
    v   = '0;
    drv = 0;
    for (int i = 0; i < n; i++) begin
      bclk = 1'b0;
      waitn(HALF);
      if (dqoe === 1'b1) drv++;
      v[i] = dqo;
      bclk = 1'b1;
      waitn(HALF);
      if (dqoe !== 1'b0) rel_err++;
    end
  endtask

  task automatic do_normal(input logic [7:0] op, input logic [63:0] code,
                           input logic [127:0] wdata, input int extra,
                           output logic [63:0] id, output int id_drv,
                           output logic [127:0] rdata, output int sec_drv,
                           output int extra_drv);
    logic [127:0] tmp;
    open_xfer();
    wr_field({104'd0, mk_cmd(op, 1'b1, 1'b0, DEV)}, 24);
    rd_field(64, tmp, id_drv);
    id = tmp[63:0];
    wr_field({64'd0, code}, 64);
    rdata   = '0;
    sec_drv = 0;
    if (op == RD_OP) rd_field(128, rdata, sec_drv);
    else             wr_field(wdata, 128);
    extra_drv = 0;
    if (extra > 0) begin
      if (op == RD_OP) rd_field(extra, tmp, extra_drv);
      else             wr_field(~wdata, extra);
    end
    close_xfer();
  endtask

  task automatic do_program(input logic [23:0] cmd, input logic [63:0] id,
                            input logic [63:0] code, output int drv);
    logic [127:0] tmp;
    open_xfer();
    wr_field({104'd0, cmd}, 24);
    wr_field({code, id}, 128);
    rd_field(4, tmp, drv);
    close_xfer();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0]  id;
    logic [127:0] rd;
    int           idd;
    int           sd;
    int           xd;
    int           pd;

    waitn(3);
    chk(dqoe === 1'b0, "R1 reset quiet", dqoe, 0);
    rst_n = 1'b1;
    waitn(4);

    // R12 / R3 / R5 / R11: empty key, zero code matches
    rel_err = 0;
    do_normal(RD_OP, 64'd0, '0, 8, id, idd, rd, sd, xd);
    chk(id == 64'd0, "R12 id after reset", id, 0);
    chk(idd == 64, "R3 id bits driven", idd, 64);
    chk(rd == '0, "R12 memory after reset", rd, 0);
    chk(sd == 128, "R5 memory bits driven", sd, 128);
    chk(xd == 0, "R11 no drive past end", xd, 0);
    chk(rel_err == 0, "R3 release on rising edge", rel_err, 0);

    // R9 program then R3/R4 readback
    do_program(mk_cmd(WR_OP, 1'b0, 1'b1, DEV), ID_A, CODE_A, pd);
    chk(pd == 0, "R9 program never drives", pd, 0);
    do_normal(RD_OP, CODE_A, '0, 0, id, idd, rd, sd, xd);
    chk(id == ID_A, "R9 R3 programmed id", id, ID_A);
    chk(rd == '0 && sd == 128, "R4 new code grants access", rd, 0);

    // R6 write with match, R11 extra writes ignored
    do_normal(WR_OP, CODE_A, WD_A, 8, id, idd, rd, sd, xd);
    chk(id == ID_A, "R3 id in write transaction", id, ID_A);
    do_normal(RD_OP, CODE_A, '0, 0, id, idd, rd, sd, xd);
    chk(rd == WD_A, "R6 R11 memory written", rd, WD_A);
    chk(rd == WD_A, "R5 memory read lsb first", rd, WD_A);

    // R7 mismatch read: driven, but not the memory
    rel_err = 0;
    do_normal(RD_OP, CODE_A ^ 64'h1, '0, 0, id, idd, rd, sd, xd);
    chk(sd == 128, "R7 random bits driven", sd, 128);
    chk(rd != WD_A, "R7 memory hidden", rd, WD_A);
    chk(rd != '0 && rd != '1, "R7 bits vary", rd, 0);
    chk(rel_err == 0, "R3 release in random read", rel_err, 0);

    // R8 mismatch write, wrong only in last code bit
    do_normal(WR_OP, CODE_A ^ 64'h8000_0000_0000_0000, WD_B, 0, id, idd, rd, sd, xd);
    do_normal(RD_OP, CODE_A, '0, 0, id, idd, rd, sd, xd);
    chk(rd == WD_A, "R8 memory kept", rd, WD_A);
    chk(id == ID_A, "R4 last bit decides match", id, ID_A);

    // R10 R2: every single-bit flip of a normal read command
    for (int b = 0; b < 24; b++) begin
      logic [127:0] t;
      int           dv;
      open_xfer();
      wr_field({104'd0, mk_cmd(RD_OP, 1'b1, 1'b0, DEV) ^ (24'd1 << b)}, 24);
      rd_field(128, t, dv);
      close_xfer();
      chk(dv == 0, $sformatf("R10 R2 read flip bit %0d silent", b), dv, 0);
    end

    // R10 R2: every single-bit flip of a program command, then read opcode
    for (int b = 0; b < 24; b++) begin
      do_program(mk_cmd(WR_OP, 1'b0, 1'b1, DEV) ^ (24'd1 << b), ID_B, CODE_B, pd);
      chk(pd == 0, $sformatf("R10 program flip bit %0d silent", b), pd, 0);
    end
    do_program(mk_cmd(RD_OP, 1'b0, 1'b1, DEV), ID_B, CODE_B, pd);
    do_normal(RD_OP, CODE_A, '0, 0, id, idd, rd, sd, xd);
    chk(id == ID_A, "R10 R2 id untouched", id, ID_A);
    chk(rd == WD_A, "R10 R2 code untouched", rd, WD_A);

    // R1 abort mid identifier
    begin
      logic [127:0] t;
      int           dv;
      open_xfer();
      wr_field({104'd0, mk_cmd(RD_OP, 1'b1, 1'b0, DEV)}, 24);
      rd_field(10, t, dv);
      chk(t[9:0] == ID_A[9:0], "R3 partial id", t[9:0], ID_A[9:0]);
      bclk = 1'b0;
      waitn(HALF);
      chk(dqoe === 1'b1, "R1 driving before abort", dqoe, 1);
      ben = 1'b0;
      #1;
      chk(dqoe === 1'b0, "R1 abort releases pin", dqoe, 0);
      waitn(HALF);
      bclk = 1'b1;
      waitn(HALF);
    end
    do_normal(RD_OP, CODE_A, '0, 0, id, idd, rd, sd, xd);
    chk(id == ID_A && rd == WD_A, "R1 restart after abort", id, ID_A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule